// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block turns a request to move one cache line into a single downstream request and four data beats of 128 bits. The downstream request carries the address rounded down to the 64-byte line boundary and a wrap flag. The data beats then run in wrap order: the first beat is the quarter of the line that holds the requested word, and the index wraps past the end of the line back to quarter 0. For a line fill, read beats arriving from downstream are passed up in the same cycle, each tagged with its quarter index, a last flag and the response code. For an eviction, the block pulls the cache's write data one quarter at a time in the same wrap order and presents it downstream.

A requester waits for `ready_o`, then pulses `start_i` with the address and the direction (`evict_i`). The block accepts nothing else until the fourth beat of that line has moved.

Top module: `lfs_line_fill_seq`

## Requirements
- R1: Out of reset `ready_o` is 1, while `dn_req_o`, `beat_act_o`, `up_rvalid_o` and `dn_wvalid_o` are 0. A `start_i` seen with `ready_o` high raises `dn_req_o` on the next cycle.
- R2: While `dn_req_o` is high, `dn_addr_o` equals the accepted address with bits [5:0] cleared, `dn_wrap_o` is 1 and `dn_write_o` equals the accepted `evict_i`. The request and its fields hold steady until a cycle in which `dn_req_rdy_i` is high.
- R3: Each accepted line produces exactly one request handshake (`dn_req_o` and `dn_req_rdy_i` both high) and exactly four beats.
- R4: The beat index `beat_idx_o` on the k-th beat (k = 0..3) is (addr[5:4] + k) mod 4, where addr is the accepted address. Bits [3:0] of the address do not affect the order.
- R5: `beat_last_o` is 1 on the fourth beat of a line and 0 on every other cycle.
- R6: In a fill, every cycle of the data phase with `dn_rvalid_i` high is one beat: `up_rvalid_o` and `beat_act_o` are 1, and `up_rdata_o` and `up_rresp_o` equal `dn_rdata_i` and `dn_rresp_i` in that same cycle.
- R7: In an eviction, `dn_wvalid_o` is 1 throughout the data phase and `dn_wdata_o` equals `up_wdata_i`. Every cycle with `dn_wready_i` high is one beat, and in it `up_wtake_o` is 1, meaning the quarter named by `beat_idx_o` was consumed.
- R8: A `start_i` that arrives while `ready_o` is 0 is ignored. No further request is issued, and the current line's beat order carries on unchanged.
- R9: In a data-phase cycle without a beat (no `dn_rvalid_i` in a fill, no `dn_wready_i` in an eviction), the beat index holds its value and neither `beat_act_o` nor `beat_last_o` is raised.
- R10: On the cycle after the fourth beat, `ready_o` is 1 again.
- R11: While idle, `dn_rvalid_i` and `dn_wready_i` are ignored: `beat_act_o`, `up_rvalid_o` and `dn_wvalid_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Line transfer request strobe |
| addr_i | input | 32 | Byte address of the critical word |
| evict_i | input | 1 | 1 = eviction (write), 0 = fill (read) |
| ready_o | output | 1 | Idle and able to accept `start_i` |
| dn_req_o | output | 1 | Downstream request valid |
| dn_req_rdy_i | input | 1 | Downstream request accepted |
| dn_addr_o | output | 32 | Line-aligned request address |
| dn_wrap_o | output | 1 | Request is a wrapping burst |
| dn_write_o | output | 1 | Request direction, 1 = write |
| dn_rvalid_i | input | 1 | Downstream read beat valid |
| dn_rdata_i | input | 128 | Downstream read beat data |
| dn_rresp_i | input | 2 | Downstream read response code |
| dn_wvalid_o | output | 1 | Write beat offered downstream |
| dn_wready_i | input | 1 | Downstream takes the write beat |
| dn_wdata_o | output | 128 | Write beat data |
| up_rvalid_o | output | 1 | Fill beat delivered to the cache |
| up_rdata_o | output | 128 | Fill beat data |
| up_rresp_o | output | 2 | Fill beat response code |
| up_wdata_i | input | 128 | Cache quarter selected by `beat_idx_o` |
| up_wtake_o | output | 1 | Eviction quarter consumed |
| beat_act_o | output | 1 | A beat moves this cycle |
| beat_idx_o | output | 2 | Quarter index of the current beat |
| beat_last_o | output | 1 | Current beat is the fourth |

## Verification
Fills are run with the critical word in each of the four quarters, so every rotation of the wrap order is seen, including a start at quarter 3 that must wrap straight to 0 after one beat. Evictions start mid-line so that the write path's rotation is compared separately from the read path's. Gaps of zero to three idle cycles between beats and a delayed request acceptance separate a design that counts beats from one that counts cycles. A `start_i` pulse in the middle of a line, and beat strobes given while idle, show whether stray inputs start or advance a sequence.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lfs_wrap_index.sv
module lfs_wrap_index #(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] count,
    output logic [IDX_W-1:0] idx
);
    // Addition in IDX_W bits wraps at the line boundary by itself.
    always_comb begin
        idx = start_idx + count;
    end
endmodule

// File: rtl/lfs_line_align.sv
module lfs_line_align #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 6
) (
    input  logic [ADDR_W-LINE_LSB-1:0] line_tag,
    output logic [ADDR_W-1:0]          line_addr
);
    generate
        if (LINE_LSB == 0) begin : g_no_offset
            assign line_addr = line_tag;
        end else begin : g_offset
            assign line_addr = {line_tag, {LINE_LSB{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/lfs_seq_ctrl.sv
module lfs_seq_ctrl
    import lfs_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BEATS   = 4,
    parameter int OFF_LSB = 4
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           start,
    input  logic [ADDR_W-1:0]                              addr,
    input  logic                                           evict,
    input  logic                                           req_rdy,
    input  logic                                           beat_fire,
    output logic                                           ready,
    output logic                                           req_on,
    output logic                                           data_on,
    output logic                                           wr,
    output logic [ADDR_W-OFF_LSB-$clog2(BEATS)-1:0]        line_tag,
    output logic [$clog2(BEATS)-1:0]                       start_idx,
    output logic [$clog2(BEATS)-1:0]                       count,
    output logic                                           at_last
);
    localparam int IDX_W    = $clog2(BEATS);
    localparam int LINE_LSB = OFF_LSB + IDX_W;
    localparam int TAG_W    = ADDR_W - LINE_LSB;
    localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(BEATS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [TAG_W-1:0] tag;
        logic             wr;
        logic [IDX_W-1:0] sidx;
        logic [IDX_W-1:0] cnt;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.st   = ST_REQ;
                    ctx_d.tag  = addr[ADDR_W-1:LINE_LSB];
                    ctx_d.wr   = evict;
                    ctx_d.sidx = addr[LINE_LSB-1:OFF_LSB];
                    ctx_d.cnt  = '0;
                end
            end
            ST_REQ: begin
                if (req_rdy) begin
                    ctx_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat_fire) begin
                    if (ctx_q.cnt == LAST_CNT) begin
                        ctx_d.st = ST_IDLE;
                    end else begin
                        ctx_d.cnt = ctx_q.cnt + IDX_W'(1);
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, tag: '0, wr: 1'b0, sidx: '0, cnt: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign ready     = (ctx_q.st == ST_IDLE);
    assign req_on    = (ctx_q.st == ST_REQ);
    assign data_on   = (ctx_q.st == ST_DATA);
    assign wr        = ctx_q.wr;
    assign line_tag  = ctx_q.tag;
    assign start_idx = ctx_q.sidx;
    assign count     = ctx_q.cnt;
    assign at_last   = (ctx_q.cnt == LAST_CNT);
endmodule

// File: rtl/lfs_line_fill_seq.sv
module lfs_line_fill_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int BEATS  = 4,
    parameter int RESP_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     evict_i,
    output logic                     ready_o,
    output logic                     dn_req_o,
    input  logic                     dn_req_rdy_i,
    output logic [ADDR_W-1:0]        dn_addr_o,
    output logic                     dn_wrap_o,
    output logic                     dn_write_o,
    input  logic                     dn_rvalid_i,
    input  logic [DATA_W-1:0]        dn_rdata_i,
    input  logic [RESP_W-1:0]        dn_rresp_i,
    output logic                     dn_wvalid_o,
    input  logic                     dn_wready_i,
    output logic [DATA_W-1:0]        dn_wdata_o,
    output logic                     up_rvalid_o,
    output logic [DATA_W-1:0]        up_rdata_o,
    output logic [RESP_W-1:0]        up_rresp_o,
    input  logic [DATA_W-1:0]        up_wdata_i,
    output logic                     up_wtake_o,
    output logic                     beat_act_o,
    output logic [$clog2(BEATS)-1:0] beat_idx_o,
    output logic                     beat_last_o
);
    localparam int IDX_W    = $clog2(BEATS);
    localparam int OFF_LSB  = $clog2(DATA_W / 8);
    localparam int LINE_LSB = OFF_LSB + IDX_W;
    localparam int TAG_W    = ADDR_W - LINE_LSB;

    logic             ready, req_on, data_on, wr, at_last, fire;
    logic [TAG_W-1:0] line_tag;
    logic [IDX_W-1:0] start_idx, count;

    // Byte offset within a beat never changes the beat order.
    logic unused_beat_off;
    assign unused_beat_off = ^addr_i[OFF_LSB-1:0];

    assign fire = data_on && (wr ? dn_wready_i : dn_rvalid_i);

    lfs_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .BEATS  (BEATS),
        .OFF_LSB(OFF_LSB)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .addr     (addr_i),
        .evict    (evict_i),
        .req_rdy  (dn_req_rdy_i),
        .beat_fire(fire),
        .ready    (ready),
        .req_on   (req_on),
        .data_on  (data_on),
        .wr       (wr),
        .line_tag (line_tag),
        .start_idx(start_idx),
        .count    (count),
        .at_last  (at_last)
    );

    lfs_wrap_index #(.IDX_W(IDX_W)) u_idx (
        .start_idx(start_idx),
        .count    (count),
        .idx      (beat_idx_o)
    );

    lfs_line_align #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_align (
        .line_tag (line_tag),
        .line_addr(dn_addr_o)
    );

    assign ready_o     = ready;
    assign dn_req_o    = req_on;
    assign dn_wrap_o   = req_on;
    assign dn_write_o  = wr;
    assign dn_wvalid_o = data_on && wr;
    assign dn_wdata_o  = up_wdata_i;
    assign up_wtake_o  = data_on && wr && dn_wready_i;
    assign up_rvalid_o = data_on && !wr && dn_rvalid_i;
    assign up_rdata_o  = dn_rdata_i;
    assign up_rresp_o  = dn_rresp_i;
    assign beat_act_o  = fire;
    assign beat_last_o = fire && at_last;
endmodule

// File: rtl/lfs_seq_chk.sv
module lfs_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    parameter int DATA_W = 128
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     ready_o,
    input logic                     dn_req_o,
    input logic                     dn_req_rdy_i,
    input logic [ADDR_W-1:0]        dn_addr_o,
    input logic                     dn_wrap_o,
    input logic                     dn_write_o,
    input logic                     dn_rvalid_i,
    input logic                     dn_wvalid_o,
    input logic                     dn_wready_i,
    input logic                     up_rvalid_o,
    input logic                     up_wtake_o,
    input logic                     beat_act_o,
    input logic [$clog2(BEATS)-1:0] beat_idx_o,
    input logic                     beat_last_o
);
    localparam int IDX_W    = $clog2(BEATS);
    localparam int LINE_LSB = $clog2(DATA_W / 8) + IDX_W;
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    // R1
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && ready_o |=> dn_req_o);
    // R2
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o |-> (dn_addr_o[LINE_LSB-1:0] == '0) && dn_wrap_o);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o && !dn_req_rdy_i |=> dn_req_o && $stable(dn_addr_o) && $stable(dn_write_o));
    // R3
    req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o && dn_req_rdy_i |=> !dn_req_o);
    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_act_o && !beat_last_o |=> beat_idx_o == $past(beat_idx_o) + ONE);
    // R5
    last_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_act_o);
    // R6
    fill_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid_o |-> dn_rvalid_i && !dn_write_o && beat_act_o);
    // R7
    evict_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_wtake_o |-> dn_wvalid_o && dn_wready_i && beat_act_o);
    // R8
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o |-> !ready_o);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o && !dn_req_o && !beat_act_o |=> $stable(beat_idx_o));
    // R10
    last_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |=> ready_o);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !beat_act_o && !up_rvalid_o && !dn_wvalid_o);
endmodule

bind lfs_line_fill_seq lfs_seq_chk #(
    .ADDR_W(ADDR_W),
    .BEATS (BEATS),
    .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ready_o     (ready_o),
    .dn_req_o    (dn_req_o),
    .dn_req_rdy_i(dn_req_rdy_i),
    .dn_addr_o   (dn_addr_o),
    .dn_wrap_o   (dn_wrap_o),
    .dn_write_o  (dn_write_o),
    .dn_rvalid_i (dn_rvalid_i),
    .dn_wvalid_o (dn_wvalid_o),
    .dn_wready_i (dn_wready_i),
    .up_rvalid_o (up_rvalid_o),
    .up_wtake_o  (up_wtake_o),
    .beat_act_o  (beat_act_o),
    .beat_idx_o  (beat_idx_o),
    .beat_last_o (beat_last_o)
);

// File: tb/sim_lfs_line_fill_seq.sv
module sim_lfs_line_fill_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  addr_i = '0;
    logic         evict_i = 1'b0;
    logic         ready_o;
    logic         dn_req_o;
    logic         dn_req_rdy_i = 1'b0;
    logic [31:0]  dn_addr_o;
    logic         dn_wrap_o;
    logic         dn_write_o;
    logic         dn_rvalid_i = 1'b0;
    logic [127:0] dn_rdata_i = '0;
    logic [1:0]   dn_rresp_i = '0;
    logic         dn_wvalid_o;
    logic         dn_wready_i = 1'b0;
    logic [127:0] dn_wdata_o;
    logic         up_rvalid_o;
    logic [127:0] up_rdata_o;
    logic [1:0]   up_rresp_o;
    logic [127:0] up_wdata_i;
    logic         up_wtake_o;
    logic         beat_act_o;
    logic [1:0]   beat_idx_o;
    logic         beat_last_o;

    lfs_line_fill_seq u0 (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic [1:0]   idx;
        logic         last;
        logic         wr;
        logic [127:0] data;
        logic [1:0]   resp;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   req_seen = 0;
    int   lines = 0;

    function automatic logic [127:0] fill_word(logic [31:0] a, int k);
        return {4{a ^ 32'(k) ^ 32'h5A00_0000}};
    endfunction

    function automatic logic [127:0] evict_word(logic [1:0] q);
        return {4{32'hE0E0_0000 | 32'(q)}};
    endfunction

    // Cache model: returns the quarter the block points at.
    always_comb up_wdata_i = evict_word(beat_idx_o);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each beat.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dn_req_o && dn_req_rdy_i) req_seen++;
            if (beat_act_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "beat with nothing expected", 128'(beat_idx_o), 128'hx);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(beat_idx_o == e.idx, "R4", "beat index", 128'(beat_idx_o), 128'(e.idx));
                    chk(beat_last_o == e.last, "R5", "last flag", 128'(beat_last_o), 128'(e.last));
                    if (e.wr) begin
                        chk(dn_wvalid_o && up_wtake_o, "R7", "write valid/take", 128'({dn_wvalid_o, up_wtake_o}), 128'h3);
                        chk(dn_wdata_o == e.data, "R7", "write data", dn_wdata_o, e.data);
                    end else begin
                        chk(up_rvalid_o, "R6", "read valid", 128'(up_rvalid_o), 128'h1);
                        chk(up_rdata_o == e.data, "R6", "read data", up_rdata_o, e.data);
                        chk(up_rresp_o == e.resp, "R6", "read resp", 128'(up_rresp_o), 128'(e.resp));
                    end
                end
            end else if (!ready_o && !dn_req_o && exp_q.size() > 0) begin
                chk(beat_idx_o == exp_q[0].idx, "R9", "index held in stall", 128'(beat_idx_o), 128'(exp_q[0].idx));
                chk(!beat_last_o, "R9", "no last in stall", 128'(beat_last_o), 128'h0);
                if (exp_q[0].wr)
                    chk(dn_wvalid_o, "R7", "write valid in data phase", 128'(dn_wvalid_o), 128'h1);
            end
        end
    end

    task automatic run_line(input logic [31:0] a, input bit wr, input int ack_dly,
                            input int pat, input bit poke);
        logic [1:0] s;
        s = a[5:4];
        lines++;
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            e.idx  = s + 2'(k);
            e.last = (k == 3);
            e.wr   = wr;
            e.data = wr ? evict_word(s + 2'(k)) : fill_word(a, k);
            e.resp = 2'(k) ^ 2'b01;
            exp_q.push_back(e);
        end
        @(posedge clk); #1;
        start_i = 1'b1; addr_i = a; evict_i = wr;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(dn_req_o, "R1", "request after start", 128'(dn_req_o), 128'h1);
        chk(dn_addr_o == {a[31:6], 6'b0}, "R2", "aligned address", 128'(dn_addr_o), 128'({a[31:6], 6'b0}));
        chk(dn_wrap_o, "R2", "wrap flag", 128'(dn_wrap_o), 128'h1);
        chk(dn_write_o == wr, "R2", "direction", 128'(dn_write_o), 128'(wr));
        repeat (ack_dly) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        dn_req_rdy_i = 1'b1;
        @(posedge clk); #1;
        dn_req_rdy_i = 1'b0;
        for (int b = 0; b < 4; b++) begin
            repeat ((pat >> (2 * b)) & 3) begin
                @(posedge clk); #1;
            end
            if (wr) dn_wready_i = 1'b1;
            else    dn_rvalid_i = 1'b1;
            dn_rdata_i = fill_word(a, b);
            dn_rresp_i = 2'(b) ^ 2'b01;
            if (poke && b == 1) begin
                start_i = 1'b1; addr_i = a ^ 32'h0000_0040; evict_i = ~wr;  // R8 stray start
            end
            @(posedge clk); #1;
            dn_wready_i = 1'b0; dn_rvalid_i = 1'b0; start_i = 1'b0;
        end
        @(negedge clk);
        chk(ready_o, "R10", "ready after last beat", 128'(ready_o), 128'h1);
        chk(exp_q.size() == 0, "R3", "all beats seen", 128'(exp_q.size()), 128'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o, "R1", "ready after reset", 128'(ready_o), 128'h1);
        chk(!dn_req_o && !beat_act_o && !up_rvalid_o && !dn_wvalid_o, "R1", "quiet after reset",
            128'({dn_req_o, beat_act_o, up_rvalid_o, dn_wvalid_o}), 128'h0);

        // R11: beat strobes while idle
        @(posedge clk); #1;
        dn_rvalid_i = 1'b1; dn_wready_i = 1'b1;
        @(negedge clk);
        chk(!beat_act_o && !up_rvalid_o && !dn_wvalid_o && !up_wtake_o, "R11", "idle strobes ignored",
            128'({beat_act_o, up_rvalid_o, dn_wvalid_o, up_wtake_o}), 128'h0);
        @(posedge clk); #1;
        dn_rvalid_i = 1'b0; dn_wready_i = 1'b0;
        @(negedge clk);
        chk(ready_o, "R11", "still idle", 128'(ready_o), 128'h1);

        run_line(32'h1000_0000, 1'b0, 0, 0,     1'b0);  // start quarter 0
        run_line(32'h1000_0050, 1'b0, 2, 8'h1B, 1'b0);  // start quarter 1
        run_line(32'h2000_00A4, 1'b0, 1, 8'hE4, 1'b1);  // start quarter 2, stray start
        run_line(32'h3000_00FC, 1'b0, 0, 8'h03, 1'b0);  // start quarter 3, offset bits set
        run_line(32'h4000_0120, 1'b1, 3, 8'h6C, 1'b0);  // eviction from quarter 2
        run_line(32'h4000_01F0, 1'b1, 0, 0,     1'b1);  // eviction from quarter 3, stray start
        run_line(32'hFFFF_FFD8, 1'b0, 0, 8'h55, 1'b0);  // top of memory, quarter 1

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_seen == lines, "R3", "one request per line", 128'(req_seen), 128'(lines));
        chk(ready_o && !dn_req_o, "R8", "no request from stray starts", 128'({ready_o, dn_req_o}), 128'h2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule